// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupts

This block gives software control over a set of general-purpose pins that are grouped into banks of equal size. Every pin owns one 32-bit control word on a plain register port. The word holds the output value and drive enable, the synchronised input level, the pull configuration, and the interrupt controls: enable, a pending flag and three trigger-select bits. The pin with global index p belongs to bank p / PINS_PER_BANK and sits at position p % PINS_PER_BANK within it. Its control word is at word address p.

After the control words, each bank has one read-only summary word at address NUM_PINS + bank. Bit n of that word is the pending flag of pin n of the bank. Each bank drives its own interrupt line toward a parent interrupt controller. Pin inputs are synchronised by two flops, and edges are found by comparing the synchronised level with its value one cycle earlier. An interrupt handler clears a pending flag by writing the control word back with the flag bit at one.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: While reset is active and after it is released, every control word reads zero, so all pins are inputs with no pull and no interrupt; all pin outputs, drive enables, pull outputs and bank interrupt lines are low.
- R2: Word address p selects pin p, where p = bank*PINS_PER_BANK + position. A write to it changes that pin's outputs only.
- R3: Control word bits: 0 output value, 1 drive enable, 2 input level (read-only), 3 pull enable, 4 pull toward high, 5 interrupt enable, 6 pending flag, 7 trigger-high, 8 trigger-low, 9 edge mode, 10 drive command (reads zero). Bit 2 shows the input as it was two clocks earlier. Bits 11 and up read zero.
- R4: With bit 9 set, the pending flag is set on a rising edge when bit 7 is set, on a falling edge when bit 8 is set, and on both edges when both are set. Other edges do not set it.
- R5: With bit 9 clear, the pending flag is set while the input is high (bit 7) or low (bit 8). If the flag is cleared while that level persists, it is set again on the following clock.
- R6: Writing a control word with bit 6 at one clears the pending flag, even if a trigger occurs in the same cycle. Writing zero to bit 6 leaves the flag unchanged.
- R7: The summary word of a bank shows each pin's pending flag whether or not the pin's interrupt is enabled. Writes to a summary address change nothing.
- R8: A bank's interrupt line is high exactly when at least one of its pins has both its pending flag and its interrupt enable set. The lines of different banks are independent.
- R9: The pull enable output follows bit 3, and the pull-high output follows bit 4. Bit 3 with bit 4 set means pull-up; bit 3 with bit 4 clear means pull-down.
- R10: A write with bit 10 set makes the pin drive: its drive enable is set, its interrupt enable is cleared, and its output value takes bit 0, all in that one write.
- R11: A read strobe returns the addressed word on rdata one clock later. rdata holds its value while no read is strobed. An address beyond the last summary word reads zero.
- R12: With both bit 7 and bit 8 clear, no input activity sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, single cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Drive enables |
| pull_en | output | NUM_PINS | Pull enables |
| pull_up | output | NUM_PINS | Pull toward high (when enabled) |
| bank_irq | output | NUM_BANKS | One interrupt line per bank |

## Verification
Each result has a fixed delay after its stimulus:
- A control write shows on the pin, pull and interrupt outputs one clock after the writing edge.
- A read result appears on rdata one clock after the strobe.
- A pin change reaches the input bit two clocks later and the pending flag three clocks later.
- A level flag that has been cleared is set again one clock after the clearing write.

A cycle-accurate behavioural model in the bench advances on the same edges and is compared with every output at each falling edge. Directed checks wait at least five clocks after a pin change before reading a summary word. The one case that depends on the exact cycle is the level flag being set again after it is cleared. It is checked on two consecutive falling edges right after the clearing write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // control word bit positions (software-visible)
  localparam int B_DOUT   = 0;
  localparam int B_OE     = 1;
  localparam int B_DIN    = 2;
  localparam int B_PEN    = 3;
  localparam int B_PUP    = 4;
  localparam int B_IEN    = 5;
  localparam int B_STS    = 6;
  localparam int B_THI    = 7;
  localparam int B_TLO    = 8;
  localparam int B_TEDGE  = 9;
  localparam int B_SETOUT = 10;
  localparam int CTRL_W   = 11;

  typedef struct packed {
    logic tedge;
    logic tlo;
    logic thi;
    logic ien;
    logic pup;
    logic pen;
    logic oe;
    logic dout;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_word,
  input  logic              in_now,
  input  logic              in_prev,
  output pin_cfg_t          cfg_q,
  output logic              sts_q,
  output logic [CTRL_W-1:0] rd_word
);
  pin_cfg_t cfg_d;
  logic     sts_d;
  logic     trig_hit;
  logic     clr_req;
  logic     unused_din;

  assign unused_din = wr_word[B_DIN];
  assign clr_req    = wr_sel & wr_word[B_STS];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_sel) begin
      cfg_d.dout  = wr_word[B_DOUT];
      cfg_d.oe    = wr_word[B_OE];
      cfg_d.pen   = wr_word[B_PEN];
      cfg_d.pup   = wr_word[B_PUP];
      cfg_d.ien   = wr_word[B_IEN];
      cfg_d.thi   = wr_word[B_THI];
      cfg_d.tlo   = wr_word[B_TLO];
      cfg_d.tedge = wr_word[B_TEDGE];
      if (wr_word[B_SETOUT]) begin
        cfg_d.oe  = 1'b1;
        cfg_d.ien = 1'b0;
      end
    end
  end

  always_comb begin
    if (cfg_q.tedge) begin
      trig_hit = (cfg_q.thi & in_now & ~in_prev) | (cfg_q.tlo & ~in_now & in_prev);
    end else begin
      trig_hit = (cfg_q.thi & in_now) | (cfg_q.tlo & ~in_now);
    end
  end

  always_comb begin
    if (clr_req) begin
      sts_d = 1'b0;
    end else if (trig_hit) begin
      sts_d = 1'b1;
    end else begin
      sts_d = sts_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sts_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    rd_word           = '0;
    rd_word[B_DOUT]   = cfg_q.dout;
    rd_word[B_OE]     = cfg_q.oe;
    rd_word[B_DIN]    = in_now;
    rd_word[B_PEN]    = cfg_q.pen;
    rd_word[B_PUP]    = cfg_q.pup;
    rd_word[B_IEN]    = cfg_q.ien;
    rd_word[B_STS]    = sts_q;
    rd_word[B_THI]    = cfg_q.thi;
    rd_word[B_TLO]    = cfg_q.tlo;
    rd_word[B_TEDGE]  = cfg_q.tedge;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_word[B_STS]) |=> !sts_q); // R6

  AST_DRIVE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_word[B_SETOUT]) |=> (cfg_q.oe && !cfg_q.ien && cfg_q.dout == $past(wr_word[B_DOUT]))); // R10

  AST_NO_TRIGGER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.thi && !cfg_q.tlo && !wr_sel && !sts_q) |=> !sts_q); // R12
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port #(
  parameter int NUM_WORDS = 18,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]                rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] ext_words;
  logic [DATA_W-1:0]            rdata_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ext
    if (i < NUM_WORDS) begin : g_real
      assign ext_words[i] = words[i];
    end else begin : g_pad
      assign ext_words[i] = '0;
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      rdata_d = ext_words[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 8,
  parameter int DATA_W        = 32,
  localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK,
  localparam int NUM_WORDS    = NUM_PINS + NUM_BANKS,
  localparam int ADDR_W       = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_PINS-1:0]  pull_en,
  output logic [NUM_PINS-1:0]  pull_up,
  output logic [NUM_BANKS-1:0] bank_irq
);
  logic [NUM_PINS-1:0]              in_sync;
  logic [NUM_PINS-1:0]              in_prev;
  logic [NUM_PINS-1:0]              sts_all;
  logic [NUM_PINS-1:0]              ien_all;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic                             unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

  gpio_in_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_raw(pin_in),
    .sync_q (in_sync),
    .prev_q (in_prev)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_cfg_t          cfg;
    logic [CTRL_W-1:0] rd_word;
    logic              wr_sel;

    assign wr_sel = wr_en && (addr == ADDR_W'(g));

    gpio_pin_cell i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (wr_sel),
      .wr_word(wdata[CTRL_W-1:0]),
      .in_now (in_sync[g]),
      .in_prev(in_prev[g]),
      .cfg_q  (cfg),
      .sts_q  (sts_all[g]),
      .rd_word(rd_word)
    );

    assign pin_out[g] = cfg.dout;
    assign pin_oe[g]  = cfg.oe;
    assign pull_en[g] = cfg.pen;
    assign pull_up[g] = cfg.pup;
    assign ien_all[g] = cfg.ien;
    assign words[g]   = {{(DATA_W-CTRL_W){1'b0}}, rd_word};
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PINS_PER_BANK-1:0] bank_sts;
    logic [PINS_PER_BANK-1:0] bank_ien;

    assign bank_sts             = sts_all[b*PINS_PER_BANK +: PINS_PER_BANK];
    assign bank_ien             = ien_all[b*PINS_PER_BANK +: PINS_PER_BANK];
    assign bank_irq[b]          = |(bank_sts & bank_ien);
    assign words[NUM_PINS + b]  = {{(DATA_W-PINS_PER_BANK){1'b0}}, bank_sts};
  end

  gpio_rd_port #(
    .NUM_WORDS(NUM_WORDS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) i_rd (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(rd_en),
    .addr (addr),
    .words(words),
    .rdata(rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bank_irq == '0 && pin_oe == '0)); // R1
endmodule

// File: tb/test_gpio_banked_ctrl.sv
module test_gpio_banked_ctrl;
  localparam int NB = 2;
  localparam int PB = 8;
  localparam int NP = NB * PB;
  localparam int AW = $clog2(NP + NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pull_en, pull_up;
  logic [NB-1:0] bank_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_banked_ctrl #(.NUM_BANKS(NB), .PINS_PER_BANK(PB), .DATA_W(32)) i_gpio_banked_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up), .bank_irq(bank_irq)
  );

  // behavioural reference model
  bit m_dout[NP], m_oe[NP], m_pen[NP], m_pup[NP], m_ien[NP];
  bit m_hi[NP], m_lo[NP], m_edge[NP], m_sts[NP];
  bit m_s1[NP], m_s2[NP], m_pv[NP];
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_word(int a);
    logic [31:0] w = 0;
    if (a < NP) begin
      w[0] = m_dout[a]; w[1] = m_oe[a]; w[2] = m_s2[a]; w[3] = m_pen[a];
      w[4] = m_pup[a]; w[5] = m_ien[a]; w[6] = m_sts[a]; w[7] = m_hi[a];
      w[8] = m_lo[a]; w[9] = m_edge[a];
    end else if (a < NP + NB) begin
      for (int n = 0; n < PB; n++) w[n] = m_sts[(a - NP) * PB + n];
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_dout[p] = 0; m_oe[p] = 0; m_pen[p] = 0; m_pup[p] = 0; m_ien[p] = 0;
        m_hi[p] = 0; m_lo[p] = 0; m_edge[p] = 0; m_sts[p] = 0;
        m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0;
      end
      m_rdata = 0;
    end else begin
      if (rd_en) m_rdata = m_word(int'(addr));
      for (int p = 0; p < NP; p++) begin
        bit ev;
        bit wsel;
        if (m_edge[p]) ev = (m_hi[p] && m_s2[p] && !m_pv[p]) || (m_lo[p] && !m_s2[p] && m_pv[p]);
        else           ev = (m_hi[p] && m_s2[p]) || (m_lo[p] && !m_s2[p]);
        wsel = wr_en && (int'(addr) == p);
        if (wsel && wdata[6]) m_sts[p] = 0;
        else if (ev)          m_sts[p] = 1;
        if (wsel) begin
          m_dout[p] = wdata[0]; m_oe[p] = wdata[1]; m_pen[p] = wdata[3];
          m_pup[p] = wdata[4]; m_ien[p] = wdata[5]; m_hi[p] = wdata[7];
          m_lo[p] = wdata[8]; m_edge[p] = wdata[9];
          if (wdata[10]) begin m_oe[p] = 1; m_ien[p] = 0; end
        end
        m_pv[p] = m_s2[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pin_in[p];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NP-1:0] e_out, e_oe, e_pen, e_pup;
      logic [NB-1:0] e_irq;
      e_irq = '0;
      for (int p = 0; p < NP; p++) begin
        e_out[p] = m_dout[p]; e_oe[p] = m_oe[p]; e_pen[p] = m_pen[p]; e_pup[p] = m_pup[p];
        if (m_sts[p] && m_ien[p]) e_irq[p / PB] = 1'b1;
      end
      chk("R3 pin_out", 32'(pin_out), 32'(e_out));
      chk("R10 pin_oe", 32'(pin_oe), 32'(e_oe));
      chk("R9 pull_en", 32'(pull_en), 32'(e_pen));
      chk("R9 pull_up", 32'(pull_up), 32'(e_pup));
      chk("R8 bank_irq", 32'(bank_irq), 32'(e_irq));
      chk("R11 rdata", rdata, m_rdata);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    rd_en = 1; addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    idle(3);
    chk("R1 oe in reset", 32'(pin_oe), 0);
    rst_n = 1;
    idle(1);
    chk("R1 irq after reset", 32'(bank_irq), 0);
    rd(5, v); chk("R1 word zero", v, 0);

    // R2 address map: word 9 is bank 1 pin 1
    wr(9, 32'h3);
    chk("R2 oe", 32'(pin_oe), 32'h0200);
    chk("R2 out", 32'(pin_out), 32'h0200);
    wr(9, 0);

    // R3 input bit
    pin_in[7] = 1; idle(3);
    rd(7, v); chk("R3 din", v, 32'h4);

    // R10 drive command overrides enable
    wr(2, 32'h20);
    wr(2, 32'h421);
    rd(2, v); chk("R10 drive", v, 32'h3);
    wr(2, 0);

    // R4 rising on pin 4
    wr(4, 32'h2A0);
    pin_in[4] = 1; idle(5);
    rd(16, v); chk("R4 rising", v, 32'h10);
    chk("R8 irq bank0", 32'(bank_irq), 32'h1);
    rd(4, v); chk("R6 readback", v, 32'h2E4);
    wr(4, v);
    chk("R6 ack clears irq", 32'(bank_irq), 0);
    pin_in[4] = 0; idle(5);
    rd(16, v); chk("R4 rising ignores fall", v, 0);
    wr(4, 32'h40);

    // R4 falling on pin 5
    wr(5, 32'h320);
    pin_in[5] = 1; idle(5);
    rd(16, v); chk("R4 falling ignores rise", v, 0);
    pin_in[5] = 0; idle(5);
    rd(16, v); chk("R4 falling", v, 32'h20);
    wr(5, 32'h40);

    // R4 both edges on pin 6, R6 write-zero keeps flag
    wr(6, 32'h3A0);
    pin_in[6] = 1; idle(5);
    rd(16, v); chk("R4 both rise", v, 32'h40);
    wr(6, 32'h3A0);
    rd(16, v); chk("R6 zero keeps flag", v, 32'h40);
    wr(6, 32'h3E0);
    rd(16, v); chk("R6 cleared", v, 0);
    pin_in[6] = 0; idle(5);
    rd(16, v); chk("R4 both fall", v, 32'h40);
    wr(6, 32'h40);

    // R5 level high on pin 8 re-asserts after clear
    pin_in[8] = 1; idle(3);
    wr(8, 32'hA0); idle(3);
    rd(17, v); chk("R5 level high", v, 32'h1);
    wr(8, 32'hE0);
    chk("R5 cleared cycle", 32'(bank_irq[1]), 0);
    @(negedge clk);
    chk("R5 set again", 32'(bank_irq[1]), 1);
    pin_in[8] = 0; idle(3);
    wr(8, 32'hE0); idle(3);
    rd(17, v); chk("R5 level gone", v, 0);
    wr(8, 32'h40);

    // R5 level low on pin 10
    wr(10, 32'h120); idle(3);
    rd(17, v); chk("R5 level low", v, 32'h4);
    chk("R8 irq bank1", 32'(bank_irq), 32'h2);
    wr(10, 32'h40);

    // R7 summary ignores enable, read-only
    wr(11, 32'h80);
    pin_in[11] = 1; idle(5);
    rd(17, v); chk("R7 summary", v, 32'h8);
    chk("R8 disabled no irq", 32'(bank_irq), 0);
    wr(17, 0);
    rd(17, v); chk("R7 write ignored", v, 32'h8);
    wr(11, 32'h40);

    // R12 no trigger selected
    wr(12, 32'h220);
    pin_in[12] = 1; idle(5);
    pin_in[12] = 0; idle(5);
    rd(17, v); chk("R12 no trigger", v, 0);
    wr(12, 0);

    // R9 pulls
    wr(13, 32'h18);
    chk("R9 pull-up en", 32'(pull_en), 32'h2000);
    chk("R9 pull-up dir", 32'(pull_up), 32'h2000);
    wr(13, 32'h08);
    chk("R9 pull-down dir", 32'(pull_up), 0);
    wr(13, 0);

    // R11 hold and out-of-range
    rd(7, held);
    addr = AW'(3); idle(3);
    chk("R11 hold", rdata, held);
    rd(30, v); chk("R11 out of range", v, 0);

    idle(2);
    finish_run();
  end
endmodule